// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point operands. Each operand has a sign bit, an 8-bit biased exponent and a 23-bit fraction. The block gives back their product in the same format, one clock after the operands are presented. The product of the two significands, with their hidden leading ones restored, can fall in [1,4). It is brought back into [1,2) with at most one right shift. It is then rounded to nearest, with ties going to the even value. If rounding carries out of the significand, the result is renormalized.

The sum of the two biased exponents, less one bias, gives the result exponent. That exponent is checked after rounding. If it is too large, the block saturates to a signed infinity. If it is too small, the block flushes to a signed zero. Each of these cases raises its own flag. Operands with a zero exponent field count as zero. An invalid flag marks a zero multiplied by an infinity. The block feeds a floating-point datapath in which a result is needed every cycle, so the output is registered but there is no handshake.

Top module: `fp32_mul_unit`

## Requirements
- R1: The sign bit (bit 31) of every result other than a NaN is the exclusive OR of the two operand sign bits.
- R2: For normal operands, the result exponent field equals ea + eb - 127 when the significand product lies in [1,2), and ea + eb - 126 when it lies in [2,4). Here ea and eb are the operand exponent fields (bits 30:23).
- R3: The 23-bit result fraction (bits 22:0) is the exact product rounded to nearest. A tie rounds to the value whose fraction bit 0 is 0.
- R4: When rounding carries out of the significand, the fraction becomes 0 and the exponent rises by one more. For example, 0x3F800001 x 0x3FFFFFFE gives 0x40000000.
- R5: When the exponent after rounding is 255 or more, the result is a signed infinity (exponent field 0xFF, fraction 0) and ovf_o is 1. Otherwise ovf_o is 0.
- R6: When the exponent after rounding is 0 or less, the result is a signed zero (bits 30:0 all 0) and unf_o is 1. Otherwise unf_o is 0.
- R7: A zero multiplied by an infinity, in either order, gives 0x7FC00000 with inv_o = 1. No other case sets inv_o.
- R8: An operand whose exponent field is 0 counts as zero, whatever its fraction. Its product with a finite value is a signed zero, and no flag is raised.
- R9: An infinity (exponent field 0xFF, fraction 0) multiplied by a nonzero non-NaN value gives a signed infinity, and no flag is raised.
- R10: If either operand is a NaN (exponent field 0xFF, fraction nonzero), the result is 0x7FC00000 and no flag is raised, even when the other operand is zero.
- R11: Result and flags change only at a rising clock edge. They reflect the operands sampled at the previous edge. While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| prod_o | output | 32 | Registered product |
| ovf_o | output | 1 | Exponent overflow; the result is a signed infinity |
| unf_o | output | 1 | Exponent underflow; the result is a signed zero |
| inv_o | output | 1 | Zero multiplied by infinity |

## Verification
The bench builds the block with its default exponent width of 8 and fraction width of 23. At those widths, the product of a pair of 24-bit significands fits in a 64-bit integer in the reference model. That puts every rounding tie, every rounding carry and the exact exponent edges at 0 and 255 within reach of directed vectors. Random operands spread over the whole exponent range then cover the sign, shift and special-value paths.

// File: rtl/fpm_pkg.sv
`timescale 1ns/1ps
package fpm_pkg;
  typedef struct packed {
    logic zero;
    logic inf;
    logic nan;
  } fpm_class_t;

  typedef enum logic [1:0] {
    SEL_NUM  = 2'd0,
    SEL_ZERO = 2'd1,
    SEL_INF  = 2'd2,
    SEL_QNAN = 2'd3
  } fpm_sel_e;
endpackage

// File: rtl/fpm_unpack.sv
`timescale 1ns/1ps
module fpm_unpack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] op,
  output logic                  sgn,
  output logic [EXP_W-1:0]      exp,
  output logic [FRAC_W:0]       sig,
  output fpm_pkg::fpm_class_t   cls
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic [FRAC_W-1:0] frac;

  always_comb begin
    sgn      = op[W-1];
    exp      = op[W-2 -: EXP_W];
    frac     = op[FRAC_W-1:0];
    sig      = {1'b1, frac};
    cls.zero = (exp == '0);
    cls.inf  = (&exp) && (frac == '0);
    cls.nan  = (&exp) && (|frac);
  end
endmodule

// File: rtl/fpm_sig_round.sv
`timescale 1ns/1ps
module fpm_sig_round #(
  parameter int FRAC_W = 23
) (
  input  logic [FRAC_W:0]   sig_a,
  input  logic [FRAC_W:0]   sig_b,
  output logic [FRAC_W-1:0] frac,
  output logic [1:0]        exp_adj
);
  localparam int SW = FRAC_W + 1;
  localparam int PW = 2 * SW;

  logic [PW-1:0] prod;
  logic          hi;
  logic [SW-1:0] keep;
  logic          guard;
  logic          sticky;
  logic          rnd;
  logic [SW:0]   sum;
  logic          carry;

  always_comb begin
    prod   = PW'(sig_a) * PW'(sig_b);
    hi     = prod[PW-1];
    keep   = hi ? prod[PW-1 -: SW] : prod[PW-2 -: SW];
    guard  = hi ? prod[PW-1-SW] : prod[PW-2-SW];
    sticky = hi ? (|prod[PW-2-SW:0]) : (|prod[PW-3-SW:0]);
    rnd    = guard & (sticky | keep[0]);
    sum    = {1'b0, keep} + {{SW{1'b0}}, rnd};
    carry  = sum[SW];
    frac   = carry ? sum[SW-1:1] : sum[SW-2:0];
    exp_adj = {1'b0, hi} + {1'b0, carry};
  end
endmodule

// File: rtl/fpm_pack.sv
`timescale 1ns/1ps
module fpm_pack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  sgn,
  input  logic [EXP_W-1:0]      exp_a,
  input  logic [EXP_W-1:0]      exp_b,
  input  logic [1:0]            exp_adj,
  input  logic [FRAC_W-1:0]     frac,
  output logic [EXP_W+FRAC_W:0] res,
  output logic                  ovf,
  output logic                  unf
);
  localparam int EW2  = EXP_W + 2;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX = (1 << EXP_W) - 1;
  localparam logic signed [EW2-1:0] BIAS_S = EW2'(BIAS);
  localparam logic signed [EW2-1:0] EMAX_S = EW2'(EMAX);

  logic signed [EW2-1:0] e_fin;

  always_comb begin
    e_fin = $signed({2'b00, exp_a}) + $signed({2'b00, exp_b})
          + $signed({{EXP_W{1'b0}}, exp_adj}) - BIAS_S;
    ovf   = !e_fin[EW2-1] && (e_fin >= EMAX_S);
    unf   = e_fin[EW2-1] || (e_fin == '0);
    if (ovf)      res = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (unf) res = {sgn, {(EXP_W+FRAC_W){1'b0}}};
    else          res = {sgn, e_fin[EXP_W-1:0], frac};
  end
endmodule

// File: rtl/fp32_mul_unit.sv
`timescale 1ns/1ps
module fp32_mul_unit #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [EXP_W+FRAC_W:0]    op_a,
  input  logic [EXP_W+FRAC_W:0]    op_b,
  output logic [EXP_W+FRAC_W:0]    prod_o,
  output logic                     ovf_o,
  output logic                     unf_o,
  output logic                     inv_o
);
  import fpm_pkg::*;

  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic             sa, sb, s_res;
  logic [EXP_W-1:0] ea, eb;
  logic [FRAC_W:0]  ma, mb;
  fpm_class_t       ca, cb;
  logic [FRAC_W-1:0] frac_r;
  logic [1:0]       adj;
  logic [W-1:0]     num_res;
  logic             num_ovf, num_unf;
  fpm_sel_e         sel;
  logic             inv_d, ovf_d, unf_d;
  logic [W-1:0]     res_d;

  fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_a (
    .op(op_a), .sgn(sa), .exp(ea), .sig(ma), .cls(ca));
  fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_b (
    .op(op_b), .sgn(sb), .exp(eb), .sig(mb), .cls(cb));

  fpm_sig_round #(.FRAC_W(FRAC_W)) u_sig (
    .sig_a(ma), .sig_b(mb), .frac(frac_r), .exp_adj(adj));

  fpm_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pack (
    .sgn(s_res), .exp_a(ea), .exp_b(eb), .exp_adj(adj), .frac(frac_r),
    .res(num_res), .ovf(num_ovf), .unf(num_unf));

  // special-case selection; NaN inputs win over zero-times-infinity
  always_comb begin
    s_res = sa ^ sb;
    sel   = SEL_NUM;
    inv_d = 1'b0;
    if (ca.nan || cb.nan) begin
      sel = SEL_QNAN;
    end else if ((ca.inf && cb.zero) || (ca.zero && cb.inf)) begin
      sel   = SEL_QNAN;
      inv_d = 1'b1;
    end else if (ca.inf || cb.inf) begin
      sel = SEL_INF;
    end else if (ca.zero || cb.zero) begin
      sel = SEL_ZERO;
    end
  end

  // next-state for the output register
  always_comb begin
    ovf_d = 1'b0;
    unf_d = 1'b0;
    unique case (sel)
      SEL_QNAN: res_d = QNAN;
      SEL_INF:  res_d = {s_res, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      SEL_ZERO: res_d = {s_res, {(W-1){1'b0}}};
      default: begin
        res_d = num_res;
        ovf_d = num_ovf;
        unf_d = num_unf;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_o <= '0;
      ovf_o  <= 1'b0;
      unf_o  <= 1'b0;
      inv_o  <= 1'b0;
    end else begin
      prod_o <= res_d;
      ovf_o  <= ovf_d;
      unf_o  <= unf_d;
      inv_o  <= inv_d;
    end
  end
endmodule

// File: rtl/fpm_mul_checker.sv
`timescale 1ns/1ps
module fpm_mul_checker #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [EXP_W+FRAC_W:0] op_a,
  input logic [EXP_W+FRAC_W:0] op_b,
  input logic [EXP_W+FRAC_W:0] prod_o,
  input logic                  ovf_o,
  input logic                  unf_o,
  input logic                  inv_o
);
  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic any_nan;
  assign any_nan = ((&op_a[W-2 -: EXP_W]) && (|op_a[FRAC_W-1:0]))
                || ((&op_b[W-2 -: EXP_W]) && (|op_b[FRAC_W-1:0]));

  p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_o, unf_o, inv_o}));

  p_ovf_inf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (prod_o[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

  p_unf_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |-> (prod_o[W-2:0] == '0));

  p_inv_qnan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_o |-> (prod_o == QNAN));

  p_nan_in_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(any_nan)) |-> (prod_o == QNAN && !inv_o));

  p_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(any_nan) && !inv_o)
      |-> (prod_o[W-1] == ($past(op_a[W-1]) ^ $past(op_b[W-1]))));
endmodule

bind fp32_mul_unit fpm_mul_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
  .prod_o(prod_o), .ovf_o(ovf_o), .unf_o(unf_o), .inv_o(inv_o));

// File: tb/sim_fp32_mul_unit.sv
`timescale 1ns/1ps
module sim_fp32_mul_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [31:0] prod_o;
  logic        ovf_o, unf_o, inv_o;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  localparam logic [31:0] QN = 32'h7FC00000;

  always #2.5 clk = ~clk;

  fp32_mul_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .prod_o(prod_o), .ovf_o(ovf_o), .unf_o(unf_o), .inv_o(inv_o));

  // behavioural reference: returns {inv, unf, ovf, result}
  function automatic logic [34:0] model(input logic [31:0] a, input logic [31:0] b);
    int ea, eb, e;
    longint m, q, rem, half;
    logic s;
    bit za, zb, ia, ib, na, nb;
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    s  = a[31] ^ b[31];
    za = (ea == 0);
    zb = (eb == 0);
    ia = (ea == 255) && (a[22:0] == 0);
    ib = (eb == 255) && (b[22:0] == 0);
    na = (ea == 255) && (a[22:0] != 0);
    nb = (eb == 255) && (b[22:0] != 0);
    if (na || nb) return {3'b000, QN};
    if ((ia && zb) || (za && ib)) return {3'b100, QN};
    if (ia || ib) return {3'b000, s, 8'hFF, 23'd0};
    if (za || zb) return {3'b000, s, 31'd0};
    m = longint'({1'b1, a[22:0]}) * longint'({1'b1, b[22:0]});
    e = ea + eb - 127;
    if (m >= (64'sd1 <<< 47)) begin
      q = m >>> 24; rem = m & ((64'sd1 <<< 24) - 1); half = 64'sd1 <<< 23; e = e + 1;
    end else begin
      q = m >>> 23; rem = m & ((64'sd1 <<< 23) - 1); half = 64'sd1 <<< 22;
    end
    if (rem > half || (rem == half && q[0])) q = q + 1;
    if (q == (64'sd1 <<< 24)) begin q = q >>> 1; e = e + 1; end
    if (e >= 255) return {3'b001, s, 8'hFF, 23'd0};
    if (e <= 0)   return {3'b010, s, 31'd0};
    return {3'b000, s, e[7:0], q[22:0]};
  endfunction

  task automatic check(input string tag, input logic [34:0] got, input logic [34:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got inv/unf/ovf=%b res=%h, expected inv/unf/ovf=%b res=%h",
               tag, got[34:32], got[31:0], exp[34:32], exp[31:0]);
    end
  endtask

  // drive at the falling edge, sample one rising edge later
  task automatic apply(input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [34:0] e;
    @(negedge clk);
    op_a = a;
    op_b = b;
    e = model(a, b);
    @(posedge clk);
    #1;
    check(tag, {inv_o, unf_o, ovf_o, prod_o}, e);
  endtask

  initial begin
    logic [34:0] held;
    #3;
    check("R11 reset", {inv_o, unf_o, ovf_o, prod_o}, 35'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    apply(32'h40000000, 32'h40400000, "R2 2x3");
    apply(32'h3FC00000, 32'h3FC00000, "R2 shift 1.5x1.5");
    apply(32'hC0000000, 32'h40400000, "R1 neg x pos");
    apply(32'hC0000000, 32'hC0400000, "R1 neg x neg");
    apply(32'h3F800001, 32'h3F800001, "R3 round down");
    apply(32'h3F800001, 32'h3FC00000, "R3 tie to odd up");
    apply(32'h3F800003, 32'h3FC00000, "R3 tie to even");
    apply(32'h3F800001, 32'h3FFFFFFE, "R4 round carry");
    check("R4 value", {inv_o, unf_o, ovf_o, prod_o}, {3'b000, 32'h40000000});
    apply(32'h7F000000, 32'h40000000, "R5 overflow");
    apply(32'hFF000000, 32'h40000000, "R5 neg overflow");
    apply(32'h7F7FFFFF, 32'h3F800001, "R5 carry overflow");
    apply(32'h7F7FFFFF, 32'h3F800000, "R5 max no overflow");
    apply(32'h00800000, 32'h3F000000, "R6 underflow");
    apply(32'h80800000, 32'h3E800000, "R6 neg underflow");
    apply(32'h00800000, 32'h3F800000, "R6 min no underflow");
    apply(32'h00000000, 32'h7F800000, "R7 zero x inf");
    apply(32'hFF800000, 32'h80000000, "R7 inf x neg zero");
    apply(32'h80000000, 32'h40400000, "R8 neg zero x 3");
    apply(32'h00000001, 32'h3F800000, "R8 denormal as zero");
    apply(32'h807FFFFF, 32'hC0000000, "R8 neg denormal");
    apply(32'hFF800000, 32'h40000000, "R9 neg inf x 2");
    apply(32'h7F800000, 32'hFF800000, "R9 inf x inf");
    apply(32'h7F800001, 32'h3F800000, "R10 nan x 1");
    apply(32'h00000000, 32'hFFC00000, "R10 zero x nan");

    // R11: output holds until the next rising edge
    @(negedge clk);
    held = {inv_o, unf_o, ovf_o, prod_o};
    op_a = 32'h40000000;
    op_b = 32'h40000000;
    #1;
    check("R11 hold", {inv_o, unf_o, ovf_o, prod_o}, held);
    @(posedge clk);
    #1;
    check("R11 update", {inv_o, unf_o, ovf_o, prod_o}, model(32'h40000000, 32'h40000000));

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom;
      if (i % 4 == 1) b[30:23] = 8'd127 - a[30:23] + 8'($urandom_range(0, 3));
      if (i % 8 == 3) a[22:0] = 23'h7FFFFF;
      apply(a, b, "R1 R2 R3 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule